// File: doc/BRIEF.md
# Free-Descriptor Pause Generator

This block watches one receive descriptor ring and asks the link partner to pause before the receive path runs out of empty descriptors. Software supplies the ring length, a low-water threshold, a release margin, and, through a one-cycle pointer write, the index of the last descriptor it has handed back. The receive engine pulses a consume input each time it takes a descriptor, and the block advances its own hardware index around the ring.

From those two indices and the ring length the block derives how many descriptors are still free. The count is taken modulo the ring length. A flag marks the fully-free state that follows reset, because there the two indices alone cannot tell a full ring from an empty one. The pause request is raised while descriptors still remain, which gives the far end time to react. It uses hysteresis, so it drops only once the count has climbed back to the threshold plus the margin. A consume that arrives when nothing is free is refused, and it latches a sticky busy error that stays set until a write-one-to-clear pulse removes it.

Top module: `fdp_pause_gen`

## Requirements
- R1: While rst is high and on the first cycle after it, hw_idx is 0, free_cnt equals ring_len, pause_req is 0 and busy_err is 0.
- R2: free_cnt equals ring_len while the ring is in the fully-free state. That state is set by reset and left on the first accepted consume or pointer write. Outside that state free_cnt is (last_free - hw_idx + 1) mod ring_len, a value from 0 to ring_len-1.
- R3: A consume pulse (take=1) seen while free_cnt is nonzero advances hw_idx by one on that clock edge and lowers free_cnt by one. The advance wraps from ring_len-1 to 0.
- R4: A consume pulse seen while free_cnt is 0 leaves hw_idx unchanged and sets busy_err from the next cycle. busy_err then stays high until it is cleared.
- R5: busy_clr=1 clears busy_err on the next cycle. When a refused consume arrives in the same cycle as busy_clr, busy_err stays set.
- R6: pause_req is 1 on the cycle after any cycle in which free_cnt < thresh.
- R7: pause_req is 0 on the cycle after any cycle in which free_cnt >= thresh + margin. For counts between these two limits it keeps its previous value.
- R8: lf_wr=1 loads lf_ptr as the last freed index, and the new free_cnt shows on the next cycle. A consume in the same cycle is judged on the count before the write, and both updates take effect together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ring_len | input | 9 | Number of descriptors in the ring, 1 to 256 |
| thresh | input | 9 | Free count below which pause is requested |
| margin | input | 9 | Extra free descriptors needed before pause is released |
| lf_wr | input | 1 | One-cycle write strobe for the last-freed pointer |
| lf_ptr | input | 8 | Index of the last descriptor freed by software |
| take | input | 1 | Receive engine consumes one descriptor |
| busy_clr | input | 1 | Write-one-to-clear for busy_err |
| hw_idx | output | 8 | Index of the next descriptor hardware will consume |
| free_cnt | output | 9 | Current number of free descriptors |
| pause_req | output | 1 | Flow-control pause request |
| busy_err | output | 1 | Sticky flag: consume attempted with no free descriptor |

## Verification
The assertions assume that ring_len, thresh and margin change only while rst is high. They also assume that lf_ptr always names a slot inside the ring, which keeps both indices below ring_len. The bench sets a new configuration only inside a reset pulse, and it draws every pointer write as a random value modulo the current ring length. Random consumes, pointer writes and clears are mixed with directed runs that drain the ring to zero, wrap the index and walk the count through the hysteresis band. A ring of length one is included, where every index is 0.

// File: rtl/fdp_pkg.sv
package fdp_pkg;
  localparam int FDP_IDX_W_DEF = 8;
  typedef enum logic {HY_RUN = 1'b0, HY_PAUSE = 1'b1} hyst_state_e;
endpackage

// File: rtl/fdp_free_calc.sv
module fdp_free_calc #(
  parameter int IDX_W = 8,
  localparam int CNT_W = IDX_W + 1,
  localparam int SUM_W = IDX_W + 2
) (
  input  logic [CNT_W-1:0] ring_len,
  input  logic [IDX_W-1:0] last_free,
  input  logic [IDX_W-1:0] idx,
  input  logic             full,
  output logic [CNT_W-1:0] count
);
  logic [SUM_W-1:0] raw, red1, red2, len_ext;

  always_comb begin
    len_ext = {1'b0, ring_len};
    raw  = {2'b00, last_free} + len_ext + SUM_W'(1) - {2'b00, idx};
    red1 = (raw  >= len_ext) ? raw  - len_ext : raw;
    red2 = (red1 >= len_ext) ? red1 - len_ext : red1;
    count = full ? ring_len : red2[CNT_W-1:0];
  end
endmodule

// File: rtl/fdp_ring_ptr.sv
module fdp_ring_ptr #(
  parameter int IDX_W = 8,
  localparam int CNT_W = IDX_W + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] ring_len,
  input  logic             lf_wr,
  input  logic [IDX_W-1:0] lf_ptr,
  input  logic             take,
  input  logic             busy_clr,
  input  logic [CNT_W-1:0] free_now,
  output logic [IDX_W-1:0] idx_q,
  output logic [IDX_W-1:0] lf_q,
  output logic             full_q,
  output logic             busy_q
);
  logic             take_ok;
  logic             take_bad;
  logic             at_end;
  logic [CNT_W-1:0] last_slot;

  always_comb begin
    last_slot = ring_len - CNT_W'(1);
    at_end    = ({1'b0, idx_q} == last_slot);
    take_ok   = take && (free_now != '0);
    take_bad  = take && (free_now == '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q  <= '0;
      lf_q   <= last_slot[IDX_W-1:0];
      full_q <= 1'b1;
      busy_q <= 1'b0;
    end else begin
      if (take_ok)
        idx_q <= at_end ? '0 : idx_q + IDX_W'(1);
      if (lf_wr)
        lf_q <= lf_ptr;
      if (take_ok || lf_wr)
        full_q <= 1'b0;
      if (take_bad)
        busy_q <= 1'b1;
      else if (busy_clr)
        busy_q <= 1'b0;
    end
  end

  // R3: an accepted consume on the last slot wraps to zero
  a_r3_wrap: assert property (@(posedge clk) disable iff (rst)
    (take && free_now != '0 && {1'b0, idx_q} == ring_len - CNT_W'(1)) |=> (idx_q == '0));
  // R4: refused consume does not move the index
  a_r4_no_advance: assert property (@(posedge clk) disable iff (rst)
    (take && free_now == '0) |=> $stable(idx_q));
  // R4: refused consume latches the busy error
  a_r4_busy_set: assert property (@(posedge clk) disable iff (rst)
    (take && free_now == '0) |=> busy_q);
  // R5: clear without a new refusal drops the flag
  a_r5_busy_clear: assert property (@(posedge clk) disable iff (rst)
    (busy_clr && !(take && free_now == '0)) |=> !busy_q);
endmodule

// File: rtl/fdp_pause_hyst.sv
module fdp_pause_hyst #(
  parameter int IDX_W = 8,
  localparam int CNT_W = IDX_W + 1,
  localparam int SUM_W = IDX_W + 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] count,
  input  logic [CNT_W-1:0] thresh,
  input  logic [CNT_W-1:0] margin,
  output logic             pause
);
  import fdp_pkg::*;
  hyst_state_e      st_q;
  logic             go_low;
  logic             go_high;
  logic [SUM_W-1:0] rel_lvl;

  always_comb begin
    rel_lvl = {1'b0, thresh} + {1'b0, margin};
    go_low  = (count < thresh);
    go_high = ({1'b0, count} >= rel_lvl);
  end

  always_ff @(posedge clk) begin
    if (rst)          st_q <= HY_RUN;
    else if (go_low)  st_q <= HY_PAUSE;
    else if (go_high) st_q <= HY_RUN;
  end

  assign pause = (st_q == HY_PAUSE);

  // R6: low count raises the request
  a_r6_raise: assert property (@(posedge clk) disable iff (rst)
    (count < thresh) |=> pause);
  // R7: recovered count drops the request
  a_r7_release: assert property (@(posedge clk) disable iff (rst)
    ({1'b0, count} >= {1'b0, thresh} + {1'b0, margin}) |=> !pause);
  // R7: inside the band the request holds
  a_r7_hold: assert property (@(posedge clk) disable iff (rst)
    (count >= thresh && {1'b0, count} < {1'b0, thresh} + {1'b0, margin}) |=> $stable(pause));
endmodule

// File: rtl/fdp_pause_gen.sv
module fdp_pause_gen #(
  parameter int IDX_W = fdp_pkg::FDP_IDX_W_DEF,
  localparam int CNT_W = IDX_W + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] ring_len,
  input  logic [CNT_W-1:0] thresh,
  input  logic [CNT_W-1:0] margin,
  input  logic             lf_wr,
  input  logic [IDX_W-1:0] lf_ptr,
  input  logic             take,
  input  logic             busy_clr,
  output logic [IDX_W-1:0] hw_idx,
  output logic [CNT_W-1:0] free_cnt,
  output logic             pause_req,
  output logic             busy_err
);
  logic [IDX_W-1:0] idx_q, lf_q;
  logic             full_q;
  logic [CNT_W-1:0] cnt;

  fdp_free_calc #(.IDX_W(IDX_W)) u_calc (
    .ring_len (ring_len),
    .last_free(lf_q),
    .idx      (idx_q),
    .full     (full_q),
    .count    (cnt)
  );

  fdp_ring_ptr #(.IDX_W(IDX_W)) u_ptr (
    .clk     (clk),
    .rst     (rst),
    .ring_len(ring_len),
    .lf_wr   (lf_wr),
    .lf_ptr  (lf_ptr),
    .take    (take),
    .busy_clr(busy_clr),
    .free_now(cnt),
    .idx_q   (idx_q),
    .lf_q    (lf_q),
    .full_q  (full_q),
    .busy_q  (busy_err)
  );

  fdp_pause_hyst #(.IDX_W(IDX_W)) u_hyst (
    .clk   (clk),
    .rst   (rst),
    .count (cnt),
    .thresh(thresh),
    .margin(margin),
    .pause (pause_req)
  );

  assign hw_idx   = idx_q;
  assign free_cnt = cnt;

  // R2: free count never exceeds the ring length
  a_r2_cnt_bound: assert property (@(posedge clk) disable iff (rst)
    free_cnt <= ring_len);
  // R3: accepted consume without a write lowers the count by one
  a_r3_dec: assert property (@(posedge clk) disable iff (rst)
    (take && !lf_wr && free_cnt != '0) |=> (free_cnt == $past(free_cnt) - CNT_W'(1)));
  // R1: leaving reset starts fully free and quiet
  a_r1_reset: assert property (@(posedge clk)
    $fell(rst) |-> (free_cnt == ring_len && !pause_req && !busy_err && hw_idx == '0));
endmodule

// File: tb/tb_fdp_pause_gen.sv
module tb_fdp_pause_gen;
  localparam int IW = 8;
  localparam int CW = IW + 1;

  logic clk = 1'b0;
  logic rst;
  logic [CW-1:0] ring_len, thresh, margin;
  logic lf_wr, take, busy_clr;
  logic [IW-1:0] lf_ptr;
  logic [IW-1:0] hw_idx;
  logic [CW-1:0] free_cnt;
  logic pause_req, busy_err;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  int m_idx, m_lf, m_len, m_thr, m_mar;
  bit m_full, m_busy, m_pause;

  always #2.5 clk = ~clk;

  fdp_pause_gen #(.IDX_W(IW)) dut (
    .clk(clk), .rst(rst), .ring_len(ring_len), .thresh(thresh), .margin(margin),
    .lf_wr(lf_wr), .lf_ptr(lf_ptr), .take(take), .busy_clr(busy_clr),
    .hw_idx(hw_idx), .free_cnt(free_cnt), .pause_req(pause_req), .busy_err(busy_err)
  );

  function automatic int mcnt();
    if (m_full) return m_len;
    return ((m_lf - m_idx + 1) % m_len + m_len) % m_len;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic check_all(input string tag);
    chk({tag, " free_cnt"}, int'(free_cnt), mcnt());
    chk({tag, " hw_idx"}, int'(hw_idx), m_idx);
    chk({tag, " pause_req"}, int'(pause_req), int'(m_pause));
    chk({tag, " busy_err"}, int'(busy_err), int'(m_busy));
  endtask

  task automatic do_reset(input int len, input int thr, input int mar);
    @(negedge clk);
    rst = 1; ring_len = CW'(len); thresh = CW'(thr); margin = CW'(mar);
    lf_wr = 0; take = 0; busy_clr = 0; lf_ptr = '0;
    @(negedge clk);
    @(negedge clk);
    rst = 0;
    m_len = len; m_thr = thr; m_mar = mar;
    m_idx = 0; m_lf = len - 1; m_full = 1; m_busy = 0; m_pause = 0;
    check_all("R1");
  endtask

  task automatic step(input bit wr, input int ptr, input bit tk, input bit clr, input string tag);
    int c;
    lf_wr = wr; lf_ptr = IW'(ptr); take = tk; busy_clr = clr;
    @(posedge clk);
    c = mcnt();
    if (c < m_thr) m_pause = 1;
    else if (c >= m_thr + m_mar) m_pause = 0;
    if (tk && c == 0) m_busy = 1;
    else if (clr) m_busy = 0;
    if (tk && c != 0) m_idx = (m_idx == m_len - 1) ? 0 : m_idx + 1;
    if (wr) m_lf = ptr;
    if ((tk && c != 0) || wr) m_full = 0;
    @(negedge clk);
    lf_wr = 0; take = 0; busy_clr = 0;
    check_all(tag);
  endtask

  task automatic random_run(input int len, input int thr, input int mar, input int n);
    do_reset(len, thr, mar);
    for (int i = 0; i < n; i++) begin
      bit wr, tk, cl;
      wr = ($urandom % 8) == 0;
      tk = ($urandom % 2) == 0;
      cl = ($urandom % 16) == 0;
      step(wr, int'($urandom % len), tk, cl, "R2/R3/R4/R5/R6/R7/R8 random");
    end
  endtask

  initial begin
    void'($urandom(32'd1234));
    rst = 1; lf_wr = 0; take = 0; busy_clr = 0; lf_ptr = '0;
    ring_len = 9'd8; thresh = 9'd3; margin = 9'd2;

    // R1 reset state for an 8-entry ring
    do_reset(8, 3, 2);
    chk("R1 free_cnt full", int'(free_cnt), 8);
    // R3 drain the ring, checking each decrement and the wrap
    for (int i = 0; i < 8; i++) step(0, 0, 1, 0, "R3 drain");
    chk("R3 wrap idx", int'(hw_idx), 0);
    chk("R2 empty count", int'(free_cnt), 0);
    chk("R6 pause after low", int'(pause_req), 1);
    // R4 consume on empty ring is refused
    step(0, 0, 1, 0, "R4 refused");
    chk("R4 idx unchanged", int'(hw_idx), 0);
    chk("R4 busy set", int'(busy_err), 1);
    step(0, 0, 0, 0, "R4 sticky");
    // R5 collision of clear and refusal keeps busy
    step(0, 0, 1, 1, "R5 collision");
    chk("R5 set wins", int'(busy_err), 1);
    step(0, 0, 0, 1, "R5 clear");
    chk("R5 cleared", int'(busy_err), 0);
    // R8/R7 free descriptors up to 4 (inside band): pause holds
    step(1, 3, 0, 0, "R8 write");
    chk("R8 count 4", int'(free_cnt), 4);
    step(0, 0, 0, 0, "R7 hold");
    chk("R7 hold high", int'(pause_req), 1);
    // R7 reach thresh+margin = 5: pause released
    step(1, 4, 0, 0, "R8 write");
    step(0, 0, 0, 0, "R7 release");
    chk("R7 released", int'(pause_req), 0);
    // R8 write and consume together
    step(1, 6, 1, 0, "R8 joint");
    chk("R8 joint count", int'(free_cnt), 6);

    // R2 wraparound in count with a ring of 13
    random_run(13, 4, 3, 3000);
    random_run(256, 32, 16, 3000);
    random_run(1, 1, 0, 300);
    random_run(100, 10, 0, 2000);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule